// File: doc/BRIEF.md
# Cold Reset Exception Entry Unit

This unit turns the release of a processor's cold-reset pin into a cold-reset exception. The active-low cold-reset input is brought into the clock domain by a two-flop synchroniser that clears at once and releases on the clock. The edge where the synchronised line leaves reset is qualified by the warm-reset pin. If warm reset is still asserted (low) at that point, the unit takes the exception. If it is not, the unit raises a one-cycle error pulse and leaves the machine state untouched. The exception cannot be masked.

On a qualified release the unit sends a one-cycle fetch redirect to the boot vector. The vector is an unmapped, uncached address, either 32-bit or sign-extended 64-bit depending on the mode select. In the same cycle it loads the state that boot code reads:

- The Status control bits take fixed values.
- The random-replacement index is set to its top value and the wired count is cleared.
- The defined Config fields take parameter constants.
- If the error level was clear, the interrupted PC is copied into the error-return register, with the current ISA mode placed in bit 0 when the compressed 16-bit ISA is enabled.

The unit samples its inputs one cycle before it applies these updates. Register bits that this unit does not define keep whatever value they held.

Top module: `cold_reset_entry`

## Requirements
- R1: `vec_valid` goes high on the fourth rising clock edge after `cold_rst_n` rises, provided `warm_rst_n` is low when the third of those edges occurs.
- R2: `vec_valid` is high for exactly one clock cycle per qualified release and stays low until the next cold reset.
- R3: If `warm_rst_n` is high at the third edge, `unqual_err` is high for one cycle on the fourth edge, `vec_valid` stays low, and no loaded register changes.
- R4: With `mode64`=0, `vec_addr` reads 0x00000000_BFC00000 during the pulse. With `mode64`=1 it reads 0xFFFFFFFF_BFC00000.
- R5: On a qualified entry, `st_ts`=0, `st_sr`=0, `st_erl`=1 and `st_bev`=1.
- R6: On a qualified entry, `random_q` is loaded with TLB_ENTRIES-1 (31 by default) and `wired_q` is loaded with 0.
- R7: If `cur_erl` was 0 and `c16_en` was 0, `error_epc` is loaded with `cur_pc` unchanged.
- R8: If `cur_erl` was 0 and `c16_en` was 1, `error_epc` is loaded with `cur_pc[63:1]` in bits 63:1 and `cur_isa` in bit 0.
- R9: If `cur_erl` was 1, `error_epc` keeps its previous value.
- R10: On a qualified entry, `config_q[31:28]` is loaded with CFG_TOP and `config_q[22:3]` is loaded with CFG_MID. All other Config bits are undefined.
- R11: While `cold_rst_n` is low, `vec_valid` and `unqual_err` are 0 and the loaded registers hold their values.
- R12: `mode64`, `c16_en`, `cur_pc`, `cur_isa` and `cur_erl` are sampled at the third edge. Changes after that edge do not affect the loaded values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| cold_rst_n | input | 1 | Cold-reset pin, active low, asynchronous |
| warm_rst_n | input | 1 | Warm-reset pin, active low; qualifies the cold release |
| mode64 | input | 1 | 1 selects the 64-bit vector form |
| c16_en | input | 1 | Compressed 16-bit ISA enabled |
| cur_pc | input | 64 | PC at the point of the exception |
| cur_isa | input | 1 | Current ISA mode bit |
| cur_erl | input | 1 | Error-level bit before entry |
| vec_valid | output | 1 | One-cycle fetch redirect strobe |
| vec_addr | output | 64 | Boot vector address |
| unqual_err | output | 1 | One-cycle pulse: cold release without warm reset |
| st_ts | output | 1 | Status TS bit |
| st_sr | output | 1 | Status SR bit |
| st_erl | output | 1 | Status error-level bit |
| st_bev | output | 1 | Status boot-vector bit |
| random_q | output | RND_W | Random-replacement index |
| wired_q | output | RND_W | Wired entry count |
| error_epc | output | 64 | Error return PC |
| config_q | output | 32 | Config register (bits 31:28 and 22:3 defined) |

## Verification
The embedded assertions check the following on every cycle:

- The redirect strobe is a single cycle and never coincides with the error pulse.
- Each strobe carries the fixed Status bits, the random index and the wired count.
- The error-return register does not move when the sampled error level was set or when the release was unqualified.

Only the bench's scenarios can show the rest:

- the exact four-edge latency from the pin;
- the vector chosen by each mode;
- the folding of the ISA bit into bit 0;
- that inputs changed after the sampling edge are ignored.

// File: rtl/cold_reset_entry.sv
module cold_reset_entry #(
  parameter int          TLB_ENTRIES = 32,
  parameter int          RND_W       = $clog2(TLB_ENTRIES),
  parameter logic [3:0]  CFG_TOP     = 4'h3,
  parameter logic [19:0] CFG_MID     = 20'h46A5C
) (
  input  logic             clk,
  input  logic             cold_rst_n,
  input  logic             warm_rst_n,
  input  logic             mode64,
  input  logic             c16_en,
  input  logic [63:0]      cur_pc,
  input  logic             cur_isa,
  input  logic             cur_erl,
  output logic             vec_valid,
  output logic [63:0]      vec_addr,
  output logic             unqual_err,
  output logic             st_ts,
  output logic             st_sr,
  output logic             st_erl,
  output logic             st_bev,
  output logic [RND_W-1:0] random_q,
  output logic [RND_W-1:0] wired_q,
  output logic [63:0]      error_epc,
  output logic [31:0]      config_q
);

  localparam logic [63:0]      VEC64   = 64'hFFFF_FFFF_BFC0_0000;
  localparam logic [63:0]      VEC32   = {32'h0, VEC64[31:0]};
  localparam logic [RND_W-1:0] RND_TOP = RND_W'(TLB_ENTRIES - 1);

  logic        sync1, sync2, seen;
  logic        rel;
  logic        take, bad;
  logic        erl_s, c16_s, isa_s, m64_s;
  logic [63:0] pc_s;

  assign rel = sync2 & ~seen;

  always_ff @(posedge clk or negedge cold_rst_n) begin
    if (!cold_rst_n) begin
      sync1      <= 1'b0;
      sync2      <= 1'b0;
      seen       <= 1'b0;
      take       <= 1'b0;
      bad        <= 1'b0;
      vec_valid  <= 1'b0;
      unqual_err <= 1'b0;
    end else begin
      sync1      <= 1'b1;
      sync2      <= sync1;
      seen       <= sync2;
      take       <= rel & ~warm_rst_n;
      bad        <= rel & warm_rst_n;
      vec_valid  <= take;
      unqual_err <= bad;
    end
  end

  always_ff @(posedge clk) begin
    if (rel) begin
      erl_s <= cur_erl;
      c16_s <= c16_en;
      isa_s <= cur_isa;
      m64_s <= mode64;
      pc_s  <= cur_pc;
    end
  end

  always_ff @(posedge clk) begin
    if (take) begin
      vec_addr        <= m64_s ? VEC64 : VEC32;
      st_ts           <= 1'b0;
      st_sr           <= 1'b0;
      st_erl          <= 1'b1;
      st_bev          <= 1'b1;
      random_q        <= RND_TOP;
      wired_q         <= '0;
      config_q[31:28] <= CFG_TOP;
      config_q[22:3]  <= CFG_MID;
      if (!erl_s)
        error_epc <= c16_s ? {pc_s[63:1], isa_s} : pc_s;
    end
  end

  // R2
  pulse_single_chk: assert property (@(posedge clk) disable iff (!cold_rst_n)
    vec_valid |=> !vec_valid);

  // R1
  pulse_follows_take_chk: assert property (@(posedge clk) disable iff (!cold_rst_n)
    vec_valid |-> $past(take));

  // R3
  err_excl_chk: assert property (@(posedge clk) disable iff (!cold_rst_n)
    unqual_err |-> !vec_valid);

  // R3
  err_no_update_chk: assert property (@(posedge clk) disable iff (!cold_rst_n)
    unqual_err |-> ($stable(error_epc) && $stable(random_q) && $stable(st_erl)));

  // R5
  status_load_chk: assert property (@(posedge clk) disable iff (!cold_rst_n)
    vec_valid |-> (st_erl && st_bev && !st_ts && !st_sr));

  // R6
  tlb_index_chk: assert property (@(posedge clk) disable iff (!cold_rst_n)
    vec_valid |-> (random_q == RND_TOP && wired_q == '0));

  // R9
  epc_hold_chk: assert property (@(posedge clk) disable iff (!cold_rst_n)
    (vec_valid && $past(erl_s)) |-> $stable(error_epc));

  // R10
  config_load_chk: assert property (@(posedge clk) disable iff (!cold_rst_n)
    vec_valid |-> (config_q[31:28] == CFG_TOP && config_q[22:3] == CFG_MID));

endmodule

// File: tb/sim_cold_reset_entry.sv
`timescale 1ns/1ps
module sim_cold_reset_entry;
  logic        clk = 1'b0;
  logic        cold_rst_n = 1'b0, warm_rst_n = 1'b1;
  logic        mode64 = 1'b0, c16_en = 1'b0, cur_isa = 1'b0, cur_erl = 1'b0;
  logic [63:0] cur_pc = '0;
  logic        vec_valid, unqual_err, st_ts, st_sr, st_erl, st_bev;
  logic [63:0] vec_addr, error_epc;
  logic [4:0]  random_q, wired_q;
  logic [31:0] config_q;

  always #2.5 clk = ~clk;

  cold_reset_entry u0 (
    .clk(clk), .cold_rst_n(cold_rst_n), .warm_rst_n(warm_rst_n), .mode64(mode64),
    .c16_en(c16_en), .cur_pc(cur_pc), .cur_isa(cur_isa), .cur_erl(cur_erl),
    .vec_valid(vec_valid), .vec_addr(vec_addr), .unqual_err(unqual_err),
    .st_ts(st_ts), .st_sr(st_sr), .st_erl(st_erl), .st_bev(st_bev),
    .random_q(random_q), .wired_q(wired_q), .error_epc(error_epc), .config_q(config_q)
  );

  int checks = 0, fails = 0;
  bit have = 0;
  logic [63:0] m_epc = '0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cmp_regs();
    if (have) begin
      chk("R5 ts",  64'(st_ts), 64'd0);
      chk("R5 sr",  64'(st_sr), 64'd0);
      chk("R5 erl", 64'(st_erl), 64'd1);
      chk("R5 bev", 64'(st_bev), 64'd1);
      chk("R6 random", 64'(random_q), 64'd31);
      chk("R6 wired", 64'(wired_q), 64'd0);
      chk("R7 R8 R9 error_epc", error_epc, m_epc);
      chk("R10 config top", 64'(config_q[31:28]), 64'h3);
      chk("R10 config mid", 64'(config_q[22:3]), 64'h46A5C);
    end
  endtask

  task automatic run_seq(input bit qual, input bit m64, input bit c16,
                         input logic [63:0] pc, input bit isa, input bit erl, input bit flip);
    @(negedge clk);
    cold_rst_n = 1'b0;
    warm_rst_n = qual ? 1'b0 : 1'b1;
    mode64 = m64; c16_en = c16; cur_pc = pc; cur_isa = isa; cur_erl = erl;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R11 valid in reset", 64'(vec_valid), 64'd0);
      chk("R11 err in reset", 64'(unqual_err), 64'd0);
      cmp_regs();
    end
    cold_rst_n = 1'b1;
    for (int n = 1; n <= 7; n++) begin
      @(negedge clk);
      if (n == 4 && qual) begin
        if (!erl) m_epc = c16 ? {pc[63:1], isa} : pc;
        have = 1;
      end
      chk("R1 R2 redirect strobe", 64'(vec_valid), 64'((n == 4) && qual));
      chk("R3 error pulse", 64'(unqual_err), 64'((n == 4) && !qual));
      if (n == 4 && qual)
        chk("R4 vector address", vec_addr, m64 ? 64'hFFFF_FFFF_BFC0_0000 : 64'h0000_0000_BFC0_0000);
      if (n == 4 && flip)
        chk("R12 sampled before change", error_epc, m_epc);
      cmp_regs();
      if (n == 3 && flip) begin
        cur_erl = ~erl; cur_pc = ~pc; cur_isa = ~isa; c16_en = ~c16; mode64 = ~m64;
      end
    end
    warm_rst_n = 1'b1;
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R11 valid at start", 64'(vec_valid), 64'd0);
    chk("R11 err at start", 64'(unqual_err), 64'd0);
    run_seq(0, 0, 0, 64'h0000_0000_1234_5678, 0, 0, 0);  // R3 before any entry
    run_seq(1, 0, 0, 64'h0000_0000_8001_2344, 0, 0, 0);  // R7, R4 32-bit
    run_seq(1, 1, 1, 64'hFFFF_FFFF_8000_1000, 1, 0, 0);  // R8 isa=1, R4 64-bit
    run_seq(1, 1, 0, 64'h0000_0000_DEAD_BEE0, 0, 1, 0);  // R9 hold
    run_seq(0, 1, 0, 64'h0000_0000_0BAD_0000, 0, 0, 0);  // R3 no change
    run_seq(1, 0, 1, 64'h0000_0000_9000_0003, 0, 0, 1);  // R12 + R8 isa=0
    run_seq(1, 1, 0, 64'hFFFF_FFFF_C000_0104, 1, 0, 0);  // R7 with c16 off
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule